// File: doc/BRIEF.md
# Memory Region Chip-Select and Wait-State Generator

This block decodes every bus address against three memory regions and drives an active-low select for the region that claims it. The low region always starts at address zero, where the interrupt vectors sit. The high region always ends at the top of the address space, where the reset fetch lands. The middle block has a programmable base and size, and it is split into equal slices, one select per slice (four by default). Each region has a size exponent, an enable bit, a count of automatically inserted wait states (0 to 3) and a bit that makes the cycle ignore the external ready input.

A bus master raises `bus_cyc` for the length of one access and holds the address stable until `rdy` is seen high. It then lowers `bus_cyc` for at least one clock before the next access. The selects are combinational from the address and the stored configuration. `rdy` is held low for the region's programmed number of wait clocks, counted from the first clock of the strobe. After that it either follows `ext_rdy` or is forced high, depending on the region's ignore bit. Software programs one region per write pulse on the configuration port.

Top module: `csw_chipsel`

## Requirements
- R1: With the low region enabled and size exponent k, `lcs_n` is low while `bus_cyc` is high and the address is below 2^k.
- R2: With the high region enabled and size exponent k, `ucs_n` is low while `bus_cyc` is high and the address is at or above 2^ADDR_W - 2^k.
- R3: With the middle region enabled, size exponent k and base B (address bits below k of B are ignored), an address whose bits above k-1 match B drives `mcs_n[i]` low. Here i is the address field at bits [k-1:k-2], so slice 0 is the lowest quarter.
- R4: A size exponent below 10 acts as 10 (1K bytes minimum), and one above ADDR_W acts as ADDR_W.
- R5: No select is low while `bus_cyc` is low, and a disabled region never asserts its select.
- R6: When regions overlap, low beats high and high beats middle, and at most one select is low at any time.
- R7: For a selected region with wait count N, `rdy` is low on the first N clocks of the strobe and may rise on clock N+1 (counted from 1).
- R8: After the wait clocks, `rdy` equals `ext_rdy` when the region's ignore bit is 0, and is high regardless of `ext_rdy` when it is 1.
- R9: An access that no region claims inserts no wait states and follows `ext_rdy`.
- R10: After reset, only the high region is enabled, with size 1K, 3 wait states and the ignore bit clear.
- R11: A pulse on `cfg_we` writes all fields of the region picked by `cfg_region`: 0 is low, 1 is high, 2 is middle, and code 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Bus address, stable during an access |
| bus_cyc | input | 1 | High for the length of one access |
| ext_rdy | input | 1 | Ready from the addressed device |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_region | input | 2 | Region picked by the write (0 low, 1 high, 2 middle, 3 none) |
| cfg_en | input | 1 | Region enable value |
| cfg_size | input | SZ_W | Size exponent, log2 of bytes |
| cfg_base | input | ADDR_W | Middle block base (used by middle writes only) |
| cfg_waits | input | 2 | Wait-state count 0..3 |
| cfg_ign_rdy | input | 1 | 1: ignore `ext_rdy` after the waits |
| lcs_n | output | 1 | Low-region select, active low |
| ucs_n | output | 1 | High-region select, active low |
| mcs_n | output | MID_DEVS | Middle-slice selects, active low |
| rdy | output | 1 | Access may complete |

## Verification
A corrupted size, base or enable register shows at the select pins in the same clock that an address in the affected span is presented, because the decode path has no register in it. A wrong wait counter or a stale strobe history shows as `rdy` rising one or more clocks early or late within a single access. The bench therefore counts the exact number of low-`rdy` clocks for each wait setting. A wrong ignore bit shows only once the wait clocks have run out, so those checks hold `ext_rdy` low well past the wait count.

// File: rtl/csw_pkg.sv
package csw_pkg;

   localparam int WAIT_W = 2;

   typedef enum logic [1:0] {
      RG_LOWER  = 2'd0,
      RG_UPPER  = 2'd1,
      RG_MIDDLE = 2'd2,
      RG_NONE   = 2'd3
   } region_e;

   typedef struct packed {
      logic [WAIT_W-1:0] waits;
      logic              ign_rdy;
   } wait_cfg_t;

endpackage

// File: rtl/csw_region_match.sv
module csw_region_match #(
   parameter int ADDR_W    = 20,
   parameter int SZ_W      = 5,
   parameter int MIN_LOG2  = 10,
   parameter int SPLIT_W   = 2,
   parameter bit SPLIT     = 1'b0
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [ADDR_W-1:0]  anchor,
   input  logic               en,
   input  logic [SZ_W-1:0]    size,
   output logic               hit,
   output logic [SPLIT_W-1:0] slice
);

   logic [SZ_W-1:0]   eff;
   logic [ADDR_W-1:0] hi_mask;

   always_comb begin
      if (int'(size) < MIN_LOG2)
         eff = SZ_W'(MIN_LOG2);
      else if (int'(size) > ADDR_W)
         eff = SZ_W'(ADDR_W);
      else
         eff = size;
   end

   assign hi_mask = {ADDR_W{1'b1}} << eff;
   assign hit     = en && ((addr & hi_mask) == (anchor & hi_mask));

   generate
      if (SPLIT) begin : g_split
         logic [ADDR_W-1:0] offset;
         logic [SZ_W-1:0]   sh;
         assign offset = addr & ~hi_mask;
         assign sh     = eff - SZ_W'(SPLIT_W);
         assign slice  = SPLIT_W'(offset >> sh);
      end else begin : g_whole
         assign slice = '0;
      end
   endgenerate

endmodule

// File: rtl/csw_wait_ctr.sv
module csw_wait_ctr
   import csw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      strobe,
   input  wait_cfg_t wcfg,
   input  logic      ext_rdy,
   output logic      rdy
);

   logic              strobe_q;
   logic              first;
   logic [WAIT_W-1:0] cnt;
   logic [WAIT_W-1:0] remaining;

   assign first     = strobe && !strobe_q;
   assign remaining = first ? wcfg.waits : cnt;
   assign rdy       = strobe && (remaining == '0) && (wcfg.ign_rdy || ext_rdy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         cnt      <= '0;
      end else begin
         strobe_q <= strobe;
         if (strobe && remaining != '0)
            cnt <= remaining - 1'b1;
         else
            cnt <= '0;
      end
   end

   assert_waits_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (first && wcfg.waits != '0) |-> !rdy);

   assert_count_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && $past(strobe) && $past(remaining) != '0) |-> remaining == $past(remaining) - 1'b1);

   assert_ext_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !wcfg.ign_rdy) |-> ext_rdy);

   assert_idle_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |-> !rdy);

endmodule

// File: rtl/csw_chipsel.sv
module csw_chipsel
   import csw_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int MID_DEVS    = 4,
   parameter int MIN_LOG2    = 10,
   parameter int RST_UP_LOG2 = 10,
   parameter int SZ_W        = $clog2(ADDR_W + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                bus_cyc,
   input  logic                ext_rdy,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_region,
   input  logic                cfg_en,
   input  logic [SZ_W-1:0]     cfg_size,
   input  logic [ADDR_W-1:0]   cfg_base,
   input  logic [WAIT_W-1:0]   cfg_waits,
   input  logic                cfg_ign_rdy,
   output logic                lcs_n,
   output logic                ucs_n,
   output logic [MID_DEVS-1:0] mcs_n,
   output logic                rdy
);

   localparam int MID_SEL_W = $clog2(MID_DEVS);

   generate
      if (MID_DEVS < 2 || (MID_DEVS & (MID_DEVS - 1)) != 0) begin : g_bad_devs
         $error("MID_DEVS must be a power of two of at least 2");
      end
      if (MIN_LOG2 < MID_SEL_W || MIN_LOG2 > ADDR_W) begin : g_bad_min
         $error("MIN_LOG2 must lie between the slice bits and ADDR_W");
      end
      if (RST_UP_LOG2 < MIN_LOG2 || RST_UP_LOG2 > ADDR_W) begin : g_bad_rst
         $error("RST_UP_LOG2 out of range");
      end
   endgenerate

   // Per-region configuration
   logic              lo_en, up_en, mid_en;
   logic [SZ_W-1:0]   lo_size, up_size, mid_size;
   logic [ADDR_W-1:0] mid_base;
   wait_cfg_t         lo_w, up_w, mid_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_en    <= 1'b0;
         lo_size  <= SZ_W'(MIN_LOG2);
         lo_w     <= '0;
         up_en    <= 1'b1;
         up_size  <= SZ_W'(RST_UP_LOG2);
         up_w     <= '{waits: '1, ign_rdy: 1'b0};
         mid_en   <= 1'b0;
         mid_size <= SZ_W'(MIN_LOG2);
         mid_base <= '0;
         mid_w    <= '0;
      end else if (cfg_we) begin
         case (region_e'(cfg_region))
            RG_LOWER: begin
               lo_en   <= cfg_en;
               lo_size <= cfg_size;
               lo_w    <= '{waits: cfg_waits, ign_rdy: cfg_ign_rdy};
            end
            RG_UPPER: begin
               up_en   <= cfg_en;
               up_size <= cfg_size;
               up_w    <= '{waits: cfg_waits, ign_rdy: cfg_ign_rdy};
            end
            RG_MIDDLE: begin
               mid_en   <= cfg_en;
               mid_size <= cfg_size;
               mid_base <= cfg_base;
               mid_w    <= '{waits: cfg_waits, ign_rdy: cfg_ign_rdy};
            end
            default: ;
         endcase
      end
   end

   // Region decode
   logic                 lo_hit, up_hit, mid_hit;
   logic [MID_SEL_W-1:0] mid_slice;
   logic [MID_SEL_W-1:0] lo_slice_nc, up_slice_nc;

   csw_region_match #(
      .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2),
      .SPLIT_W(MID_SEL_W), .SPLIT(1'b0)
   ) u_lower (
      .addr(addr), .anchor({ADDR_W{1'b0}}), .en(lo_en), .size(lo_size),
      .hit(lo_hit), .slice(lo_slice_nc)
   );

   csw_region_match #(
      .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2),
      .SPLIT_W(MID_SEL_W), .SPLIT(1'b0)
   ) u_upper (
      .addr(addr), .anchor({ADDR_W{1'b1}}), .en(up_en), .size(up_size),
      .hit(up_hit), .slice(up_slice_nc)
   );

   csw_region_match #(
      .ADDR_W(ADDR_W), .SZ_W(SZ_W), .MIN_LOG2(MIN_LOG2),
      .SPLIT_W(MID_SEL_W), .SPLIT(1'b1)
   ) u_middle (
      .addr(addr), .anchor(mid_base), .en(mid_en), .size(mid_size),
      .hit(mid_hit), .slice(mid_slice)
   );

   region_e sel;

   always_comb begin
      if (lo_hit)       sel = RG_LOWER;
      else if (up_hit)  sel = RG_UPPER;
      else if (mid_hit) sel = RG_MIDDLE;
      else              sel = RG_NONE;
   end

   assign lcs_n = !(bus_cyc && sel == RG_LOWER);
   assign ucs_n = !(bus_cyc && sel == RG_UPPER);

   generate
      for (genvar i = 0; i < MID_DEVS; i++) begin : g_mcs
         assign mcs_n[i] = !(bus_cyc && sel == RG_MIDDLE && mid_slice == MID_SEL_W'(i));
      end
   endgenerate

   // Wait-state selection and counter
   wait_cfg_t act_w;

   always_comb begin
      case (sel)
         RG_LOWER:  act_w = lo_w;
         RG_UPPER:  act_w = up_w;
         RG_MIDDLE: act_w = mid_w;
         default:   act_w = '0;
      endcase
   end

   csw_wait_ctr u_wait (
      .clk(clk), .rst_n(rst_n), .strobe(bus_cyc), .wcfg(act_w),
      .ext_rdy(ext_rdy), .rdy(rdy)
   );

   assert_single_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~lcs_n, ~ucs_n, ~mcs_n}) <= 1);

   assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cyc |-> (lcs_n && ucs_n && (&mcs_n)));

   assert_lower_beats_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cyc && lo_hit) |-> (!lcs_n && ucs_n));

   assert_mid_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~mcs_n));

   assert_disabled_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mid_en |-> (&mcs_n));

endmodule

// File: tb/tb_csw_chipsel.sv
module tb_csw_chipsel;
   localparam int AW   = 20;
   localparam int SW   = 5;
   localparam int NVEC = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          bus_cyc = 1'b0;
   logic          ext_rdy = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_region = '0;
   logic          cfg_en = 1'b0;
   logic [SW-1:0] cfg_size = '0;
   logic [AW-1:0] cfg_base = '0;
   logic [1:0]    cfg_waits = '0;
   logic          cfg_ign_rdy = 1'b0;
   logic          lcs_n, ucs_n, rdy;
   logic [3:0]    mcs_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   csw_chipsel dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .bus_cyc(bus_cyc), .ext_rdy(ext_rdy),
      .cfg_we(cfg_we), .cfg_region(cfg_region), .cfg_en(cfg_en), .cfg_size(cfg_size),
      .cfg_base(cfg_base), .cfg_waits(cfg_waits), .cfg_ign_rdy(cfg_ign_rdy),
      .lcs_n(lcs_n), .ucs_n(ucs_n), .mcs_n(mcs_n), .rdy(rdy)
   );

   // {address, expected code}: 0 none, 1 low, 2 high, 3+i middle slice i
   localparam logic [23:0] VEC [NVEC] = '{
      {20'h00000, 4'd1}, {20'h00FFF, 4'd1}, {20'h01000, 4'd0},
      {20'hFC000, 4'd2}, {20'hFBFFF, 4'd0}, {20'hFFFFF, 4'd2},
      {20'h40000, 4'd3}, {20'h44000, 4'd4}, {20'h4BFFF, 4'd5},
      {20'h4FFFF, 4'd6}, {20'h50000, 4'd0}, {20'h3FFFF, 4'd0}
   };

   function automatic logic [5:0] exp_cs(input logic [3:0] code);
      logic [5:0] v = 6'b111111;
      if (code == 4'd1) v[5] = 1'b0;
      else if (code == 4'd2) v[4] = 1'b0;
      else if (code >= 4'd3) v[code - 4'd3] = 1'b0;
      return v;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [1:0] rg, input logic en, input logic [SW-1:0] sz,
                      input logic [AW-1:0] base, input logic [1:0] w, input logic ign);
      @(negedge clk);
      cfg_region = rg; cfg_en = en; cfg_size = sz; cfg_base = base;
      cfg_waits = w; cfg_ign_rdy = ign; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic cs_probe(input logic [AW-1:0] a, input logic [3:0] code, input string tag);
      @(negedge clk);
      addr = a; bus_cyc = 1'b1;
      #1 check(tag, {26'd0, lcs_n, ucs_n, mcs_n}, {26'd0, exp_cs(code)});
      @(negedge clk);
      bus_cyc = 1'b0;
   endtask

   task automatic wait_probe(input logic [AW-1:0] a, input logic ext, input int exp_n,
                             input string tag);
      int n = 0;
      @(negedge clk);
      addr = a; ext_rdy = ext; bus_cyc = 1'b1;
      #1;
      while (!rdy && n < 12) begin
         @(negedge clk);
         #1 n++;
      end
      check(tag, n, exp_n);
      @(negedge clk);
      bus_cyc = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10: reset state, high region 1K with 3 waits, others off
      cs_probe(20'hFFC00, 4'd2, "R10 high 1K bottom");
      cs_probe(20'hFFBFF, 4'd0, "R10 below high 1K");
      cs_probe(20'h00000, 4'd0, "R10 low disabled");
      wait_probe(20'hFFC00, 1'b1, 3, "R10 three waits");

      // R5: no strobe, no select
      @(negedge clk);
      addr = 20'hFFFFF; bus_cyc = 1'b0;
      #1 check("R5 idle strobe", {26'd0, lcs_n, ucs_n, mcs_n}, {26'd0, 6'b111111});

      // R11: program all three regions
      cfg(2'd0, 1'b1, 5'd12, '0, 2'd0, 1'b1);
      cfg(2'd1, 1'b1, 5'd14, '0, 2'd2, 1'b0);
      cfg(2'd2, 1'b1, 5'd16, 20'h40123, 2'd1, 1'b1);

      // R1 R2 R3: decode table
      for (int i = 0; i < NVEC; i++) begin
         string t;
         case (VEC[i][3:0])
            4'd1:    t = "R1 low decode";
            4'd2:    t = "R2 high decode";
            4'd0:    t = "R5 unclaimed decode";
            default: t = "R3 middle slice decode";
         endcase
         cs_probe(VEC[i][23:4], VEC[i][3:0], t);
      end

      // R11: region code 3 writes nothing
      cfg(2'd3, 1'b1, 5'd31, 20'hFFFFF, 2'd3, 1'b0);
      cs_probe(20'h01000, 4'd0, "R11 code 3 ignored above low");
      cs_probe(20'h4FFFF, 4'd6, "R11 code 3 ignored middle");

      // R7 R8 R9: wait states and ready handling
      wait_probe(20'h00010, 1'b0, 0, "R8 low zero waits ignore ext");
      wait_probe(20'hFFFF0, 1'b1, 2, "R7 high two waits");
      wait_probe(20'h48000, 1'b0, 1, "R7 middle one wait ignore ext");
      wait_probe(20'h60000, 1'b1, 0, "R9 unclaimed immediate");

      // R8: high region holds on external ready after its waits
      @(negedge clk);
      addr = 20'hFFFF0; ext_rdy = 1'b0; bus_cyc = 1'b1;
      repeat (5) @(negedge clk);
      #1 check("R8 high waits for ext", rdy, 1'b0);
      ext_rdy = 1'b1;
      #1 check("R8 high ext released", rdy, 1'b1);
      @(negedge clk);
      bus_cyc = 1'b0;

      // R9: unclaimed follows ext low
      @(negedge clk);
      addr = 20'h60000; ext_rdy = 1'b0; bus_cyc = 1'b1;
      repeat (3) @(negedge clk);
      #1 check("R9 unclaimed follows ext", rdy, 1'b0);
      @(negedge clk);
      bus_cyc = 1'b0;

      // R4: exponent below minimum acts as 1K
      cfg(2'd0, 1'b1, 5'd3, '0, 2'd0, 1'b1);
      cs_probe(20'h003FF, 4'd1, "R4 low clamp inside");
      cs_probe(20'h00400, 4'd0, "R4 low clamp outside");

      // R5: disabled middle
      cfg(2'd2, 1'b0, 5'd16, 20'h40000, 2'd1, 1'b1);
      cs_probe(20'h40000, 4'd0, "R5 middle disabled");

      // R6 R4: high exponent past ADDR_W covers all; priority
      cfg(2'd2, 1'b1, 5'd16, 20'h40000, 2'd1, 1'b1);
      cfg(2'd1, 1'b1, 5'd31, '0, 2'd0, 1'b1);
      cs_probe(20'h00400, 4'd2, "R4 high clamp whole space");
      cs_probe(20'h003FF, 4'd1, "R6 low beats high");
      cs_probe(20'h40000, 4'd2, "R6 high beats middle");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule